// File: doc/BRIEF.md
# Two-Wire Serial Memory Bus Front End

This block is the bus-side receiver of a byte-addressed serial memory on a two-wire bus with an open-drain data line. It oversamples the clock and data lines on the system clock, recognises Start and Stop conditions, and assembles bytes on rising clock edges. The first byte after any Start is treated as a control byte. It holds a fixed four-bit device code, three chip-select bits that must equal three strap inputs, and a direction bit in the least significant position.

When the control byte matches, the block acknowledges by pulling the data line low for the ninth clock. It also publishes the transfer direction. In a write, the next byte is presented once as the word address, and every later byte is presented once as a data byte for a separate write engine. Each of these bytes is acknowledged. A read is acknowledged at the control byte only; delivering read data is left to other logic. While the write engine reports an internal write cycle, no byte of any kind is acknowledged or forwarded. Every Stop is reported as a single-cycle pulse.

Top module: `i2c_mem_front`

## Requirements
- R1: A control byte whose upper four bits differ from binary 1010 is never acknowledged, and no address or data byte follows from it.
- R2: The chip-select field (control byte bits 3 down to 1) must equal `chipSel` for the control byte to be acknowledged; any other value leaves the data line released.
- R3: After a matching control byte, and after each accepted address or data byte, the block holds the data line low while the clock is high for the ninth clock of that byte.
- R4: Outside the acknowledge clock the block never drives the data line, so during every data bit the line carries the value the transmitter sent.
- R5: On a matched control byte, `readSel` takes the value of control bit 0 (1 = read, 0 = write) and holds it until the next matched control byte.
- R6: In a write, the byte after the control byte appears on `addrByte` with `addrValid` high for exactly one cycle, and it is acknowledged.
- R7: Each byte after the address byte in a write appears on `dataByte` with `dataValid` high for exactly one cycle, and it is acknowledged.
- R8: While `wrBusy` is high, no byte is acknowledged, and `addrValid` and `dataValid` stay low.
- R9: A Start seen partway through a byte clears the bit count, so the next eight bits are decoded as a fresh control byte.
- R10: Each Stop gives one single-cycle pulse on `stopSeen` and returns the block to idle, where bytes sent without a new Start are not acknowledged.
- R11: After reset, `sdaDrvLow`, `readSel`, `addrValid`, `dataValid` and `stopSeen` are all low.
- R12: After a matched read control byte, no further byte of that transfer is acknowledged or forwarded as an address or data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired result) |
| sdaDrvLow | output | 1 | When high, the data line is pulled low |
| chipSel | input | 3 | Strap levels compared with the chip-select field |
| wrBusy | input | 1 | Internal write cycle in progress |
| addrValid | output | 1 | One-cycle strobe: word address received |
| addrByte | output | 8 | Word address byte |
| dataValid | output | 1 | One-cycle strobe: write data byte received |
| dataByte | output | 8 | Write data byte |
| readSel | output | 1 | Direction of the last matched control byte, 1 = read |
| stopSeen | output | 1 | One-cycle strobe on each Stop condition |

## Verification
The control byte is swept over every pairing of strap value, chip-select field and direction bit. This separates a comparison against the straps from one against a constant, and shows that the direction bit alters the path taken without affecting the match. Every non-matching device code is then tried with a matching chip select to isolate the device-code compare. Separate transfers cover several data bytes in a row, a Start injected after four bits, a transfer held off by a busy write engine, and bytes sent after a Stop with no new Start. These show whether the bit counter, the busy gating and the idle return each act on their own.

// File: rtl/i2c_mem_front_pkg.sv
package i2c_mem_front_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef struct packed {
    logic ackReq;
    logic addrLoad;
    logic dataLoad;
    logic dirLoad;
  } frontStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } frontState_t;

endpackage

// File: rtl/i2c_mem_front_dp.sv
module i2c_mem_front_dp
  import i2c_mem_front_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  frontStrobe_t      stb,
  output logic              startEv,
  output logic              stopEv,
  output logic              byteDone,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdaDrvLow,
  output logic              addrValid,
  output logic [DATA_W-1:0] addrByte,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              readSel,
  output logic              stopSeen
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall;
  logic [CNT_W-1:0]  bitCnt;
  logic              inAck;
  logic              ackArm;
  logic [DATA_W-2:0] shiftReg;

  // Two-flop (or deeper) input synchronizers
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end

  assign startEv  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign byteDone = sclRise & ~inAck & (bitCnt == LAST_BIT);
  assign rxByte   = {shiftReg, sdaS};

  // Bit counter and shifter; count DATA_W marks the acknowledge slot
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt   <= '0;
      inAck    <= 1'b0;
      shiftReg <= '0;
    end else if (startEv || stopEv) begin
      bitCnt <= '0;
      inAck  <= 1'b0;
    end else if (sclRise) begin
      if (bitCnt == ACK_BIT) begin
        inAck <= 1'b1;
      end else begin
        shiftReg <= rxByte[DATA_W-2:0];
        bitCnt   <= bitCnt + 1'b1;
      end
    end else if (sclFall && inAck) begin
      bitCnt <= '0;
      inAck  <= 1'b0;
    end

  // Open-drain acknowledge drive
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sdaDrvLow <= 1'b0;
      ackArm    <= 1'b0;
    end else if (startEv || stopEv) begin
      sdaDrvLow <= 1'b0;
      ackArm    <= 1'b0;
    end else begin
      if (stb.ackReq) ackArm <= 1'b1;
      if (sclFall && ackArm && !inAck && bitCnt == ACK_BIT) begin
        sdaDrvLow <= 1'b1;
        ackArm    <= 1'b0;
      end else if (sclFall && inAck) begin
        sdaDrvLow <= 1'b0;
      end
    end

  // Byte hand-off registers
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      addrValid <= 1'b0;
      dataValid <= 1'b0;
      addrByte  <= '0;
      dataByte  <= '0;
      readSel   <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      addrValid <= stb.addrLoad;
      dataValid <= stb.dataLoad;
      stopSeen  <= stopEv;
      if (stb.addrLoad) addrByte <= rxByte;
      if (stb.dataLoad) dataByte <= rxByte;
      if (stb.dirLoad)  readSel  <= rxByte[0];
    end

endmodule

// File: rtl/i2c_mem_front_ctrl.sv
module i2c_mem_front_ctrl
  import i2c_mem_front_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [CS_W-1:0]   chipSel,
  input  logic              wrBusy,
  output frontStrobe_t      stb
);

  frontState_t state, nextState;
  logic ctrlMatch;

  assign ctrlMatch = (rxByte[DATA_W-1 -: 4] == DEV_CODE) &&
                     (rxByte[CS_W:1] == chipSel) && !wrBusy;

  always_comb begin
    stb       = '0;
    nextState = state;
    if (startEv) begin
      nextState = ST_CTRL;
    end else if (stopEv) begin
      nextState = ST_IDLE;
    end else if (byteDone) begin
      unique case (state)
        ST_CTRL: begin
          if (ctrlMatch) begin
            stb.ackReq  = 1'b1;
            stb.dirLoad = 1'b1;
            nextState   = rxByte[0] ? ST_SKIP : ST_ADDR;
          end else begin
            nextState = ST_SKIP;
          end
        end
        ST_ADDR: begin
          if (!wrBusy) begin
            stb.ackReq   = 1'b1;
            stb.addrLoad = 1'b1;
            nextState    = ST_DATA;
          end else begin
            nextState = ST_SKIP;
          end
        end
        ST_DATA: begin
          if (!wrBusy) begin
            stb.ackReq   = 1'b1;
            stb.dataLoad = 1'b1;
          end else begin
            nextState = ST_SKIP;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;

endmodule

// File: rtl/i2c_mem_front.sv
module i2c_mem_front
  import i2c_mem_front_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  input  logic [CS_W-1:0]   chipSel,
  input  logic              wrBusy,
  output logic              addrValid,
  output logic [DATA_W-1:0] addrByte,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              readSel,
  output logic              stopSeen
);

  frontStrobe_t      stb;
  logic              startEv, stopEv, byteDone;
  logic [DATA_W-1:0] rxByte;

  i2c_mem_front_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .startEv(startEv), .stopEv(stopEv), .byteDone(byteDone), .rxByte(rxByte),
    .sdaDrvLow(sdaDrvLow), .addrValid(addrValid), .addrByte(addrByte),
    .dataValid(dataValid), .dataByte(dataByte), .readSel(readSel),
    .stopSeen(stopSeen)
  );

  i2c_mem_front_ctrl #(.DATA_W(DATA_W), .CS_W(CS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .byteDone(byteDone), .rxByte(rxByte), .chipSel(chipSel),
    .wrBusy(wrBusy), .stb(stb)
  );

endmodule

// File: rtl/i2c_mem_front_chk.sv
module i2c_mem_front_chk (
  input logic clk,
  input logic rstN,
  input logic wrBusy,
  input logic sdaDrvLow,
  input logic addrValid,
  input logic dataValid,
  input logic stopSeen,
  input logic readSel
);

  logic [6:0] busyRun;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                busyRun <= '0;
    else if (!wrBusy)         busyRun <= '0;
    else if (busyRun != 7'h7F) busyRun <= busyRun + 1'b1;

  // R8: a long busy stretch leaves the line released
  p_busy_no_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyRun == 7'h7F) |-> !sdaDrvLow);

  // R8: no byte forwarded during a long busy stretch
  p_busy_no_fwd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyRun == 7'h7F) |-> !(addrValid || dataValid));

  // R6: address strobe lasts one cycle and only in write direction
  p_addr_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);
  p_addr_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> !readSel);

  // R7: data strobe lasts one cycle and only in write direction
  p_data_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);
  p_data_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !readSel);

  // R10: stop strobe lasts one cycle
  p_stop_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !stopSeen);

  // R6, R7, R10: strobes never coincide
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrValid, dataValid, stopSeen}));

endmodule

bind i2c_mem_front i2c_mem_front_chk chk_i (
  .clk(clk), .rstN(rstN), .wrBusy(wrBusy), .sdaDrvLow(sdaDrvLow),
  .addrValid(addrValid), .dataValid(dataValid), .stopSeen(stopSeen),
  .readSel(readSel)
);

// File: tb/i2c_mem_front_tb_top.sv
module i2c_mem_front_tb_top;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       busy = 1'b0;
  logic       sdaDrvLow, addrValid, dataValid, readSel, stopSeen;
  logic [7:0] addrByte, dataByte;
  logic       sdaLine;

  int checks = 0;
  int fails = 0;
  int addrCnt = 0;
  int dataCnt = 0;
  int stopCnt = 0;
  logic [7:0] lastAddr = 8'h00;
  logic [7:0] lastData = 8'h00;
  bit finished = 1'b0;

  assign sdaLine = sdaM & ~sdaDrvLow;

  always #2.5 clk = ~clk;

  i2c_mem_front dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .chipSel(strap), .wrBusy(busy),
    .addrValid(addrValid), .addrByte(addrByte), .dataValid(dataValid),
    .dataByte(dataByte), .readSel(readSel), .stopSeen(stopSeen)
  );

  always @(negedge clk) begin
    if (addrValid) begin addrCnt++; lastAddr = addrByte; end
    if (dataValid) begin dataCnt++; lastData = dataByte; end
    if (stopSeen) stopCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    waitc(2); sdaM = b; waitc(H - 2);
    scl = 1'b1; waitc(H / 2);
    check(sdaLine == b, "R4 line follows transmitter", int'(sdaLine), int'(b));
    waitc(H / 2); scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    waitc(2); sdaM = 1'b1; waitc(H - 2);
    scl = 1'b1; waitc(H / 2);
    acked = !sdaLine;
    waitc(H / 2); scl = 1'b0;
  endtask

  task automatic doStart();
    waitc(2); sdaM = 1'b1; waitc(H);
    scl = 1'b1; waitc(H);
    sdaM = 1'b0; waitc(H);
    scl = 1'b0;
  endtask

  task automatic doStop();
    waitc(2); sdaM = 1'b0; waitc(H);
    scl = 1'b1; waitc(H);
    sdaM = 1'b1; waitc(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    int sc, ac, dc;
    waitc(4);
    rstN = 1'b1;
    waitc(2);
    // R11: reset state
    check(!sdaDrvLow && !readSel && !addrValid && !dataValid && !stopSeen,
          "R11 reset outputs", int'({sdaDrvLow, readSel, addrValid, dataValid, stopSeen}), 0);

    // R2, R3, R5, R6, R12: sweep strap x chip-select x direction
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int rw = 0; rw < 2; rw++) begin
          logic [7:0] ctl;
          logic [7:0] adr;
          bit prevDir;
          strap = 3'(s);
          ctl = {4'b1010, 3'(c), 1'(rw)};
          adr = 8'((s * 16 + c * 2 + rw) ^ 8'h5A);
          prevDir = readSel;
          ac = addrCnt; sc = stopCnt;
          doStart();
          sendByte(ctl, ack);
          check(ack == (s == c), "R2 R3 control match ack", int'(ack), int'(s == c));
          waitc(2);
          if (s == c)
            check(readSel == 1'(rw), "R5 direction", int'(readSel), rw);
          else
            check(readSel == prevDir, "R5 direction held", int'(readSel), int'(prevDir));
          sendByte(adr, ack);
          waitc(2);
          if (s == c && rw == 0) begin
            check(ack, "R6 address ack", int'(ack), 1);
            check(addrCnt == ac + 1 && lastAddr == adr, "R6 address value",
                  int'(lastAddr), int'(adr));
          end else begin
            check(!ack, "R12 no ack after read or mismatch", int'(ack), 0);
            check(addrCnt == ac, "R12 no address forwarded", addrCnt, ac);
          end
          doStop();
          waitc(2);
          check(stopCnt == sc + 1, "R10 stop pulse", stopCnt, sc + 1);
        end
      end
    end

    // R1: every other device code with matching chip select
    strap = 3'd5;
    for (int code = 0; code < 16; code++) begin
      if (code != 10) begin
        ac = addrCnt;
        doStart();
        sendByte({4'(code), 3'd5, 1'b0}, ack);
        check(!ack, "R1 device code mismatch", int'(ack), 0);
        sendByte(8'h11, ack);
        waitc(2);
        check(!ack && addrCnt == ac, "R1 nothing forwarded", addrCnt, ac);
        doStop();
      end
    end

    // R7: several data bytes in one write
    strap = 3'd2;
    doStart();
    sendByte({4'b1010, 3'd2, 1'b0}, ack);
    check(ack, "R3 control ack", int'(ack), 1);
    sendByte(8'h37, ack);
    check(ack, "R6 address ack", int'(ack), 1);
    begin
      logic [7:0] vals [3] = '{8'hA5, 8'h3C, 8'hFF};
      for (int k = 0; k < 3; k++) begin
        dc = dataCnt;
        sendByte(vals[k], ack);
        waitc(2);
        check(ack, "R7 data ack", int'(ack), 1);
        check(dataCnt == dc + 1 && lastData == vals[k], "R7 data value",
              int'(lastData), int'(vals[k]));
      end
    end
    doStop();

    // R9: Start after four bits realigns to a new control byte
    doStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    doStart();
    sendByte({4'b1010, 3'd2, 1'b0}, ack);
    check(ack, "R9 control after mid-byte start", int'(ack), 1);
    sendByte(8'h6E, ack);
    waitc(2);
    check(ack && lastAddr == 8'h6E, "R9 address after mid-byte start",
          int'(lastAddr), 32'h6E);
    doStop();

    // R8: busy write engine suppresses every acknowledge
    busy = 1'b1;
    ac = addrCnt; dc = dataCnt;
    doStart();
    sendByte({4'b1010, 3'd2, 1'b0}, ack);
    check(!ack, "R8 control not acked while busy", int'(ack), 0);
    sendByte(8'h22, ack);
    check(!ack, "R8 address not acked while busy", int'(ack), 0);
    sendByte(8'h33, ack);
    waitc(2);
    check(!ack && addrCnt == ac && dataCnt == dc, "R8 nothing forwarded while busy",
          addrCnt + dataCnt, ac + dc);
    doStop();
    busy = 1'b0;

    // R10: after Stop, bytes without a new Start are ignored
    ac = addrCnt;
    doStart();
    sendByte({4'b1010, 3'd2, 1'b0}, ack);
    doStop();
    waitc(2); scl = 1'b0; waitc(H);
    sendByte({4'b1010, 3'd2, 1'b0}, ack);
    check(!ack, "R10 idle after stop", int'(ack), 0);
    sendByte(8'h44, ack);
    waitc(2);
    check(!ack && addrCnt == ac, "R10 no address in idle", addrCnt, ac);
    doStart();
    doStop();

    waitc(4);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule